// File: doc/BRIEF.md
# Shadow and Channel Memory Map Decoder

This block routes memory accesses in the upper part of a 1 MB real-mode address space. For every access it looks at the 20-bit address and at a set of configuration bytes, and it decides where the read path points and where the write path points. Each path goes either to system-board memory or to the expansion I/O channel. The decode is pure combinational logic. A bus controller applies the result to the access it is running, so a change to a configuration byte steers the very next access.

Two address ranges are decoded, both in 16 KB granules. In the range 0x40000–0xBFFFF, each granule has one select bit, and that bit moves reads and writes together. In the range 0xC0000–0xFFFFF, each granule also has one select bit that forces the whole granule onto the channel. When that bit is clear, the granule falls under a shadow setting. The shadow setting is held per 64 KB group and gives reads and writes separate control bits, so a ROM image can be read from one side while it is written to the other. Addresses below 0x40000 are not configurable and always go to the board.

Top module: `memmap_decoder`

## Requirements
- R1: For any address below 0x40000, rd_ext_o and wr_ext_o are both 0 (board memory), whatever the configuration.
- R2: For an address in 0x40000–0xBFFFF, take block n = (addr − 0x40000) >> 14, in the range 0..31. If bit n of low_map_i is 1, both rd_ext_o and wr_ext_o are 1 (channel). Bit n of low_map_i is bit n mod 8 of configuration byte n/8, and bytes 0..3 sit at bits [7:0]..[31:24].
- R3: For an address in 0x40000–0xBFFFF whose block bit in low_map_i is 0, both rd_ext_o and wr_ext_o are 0.
- R4: For an address in 0xC0000–0xFFFFF, take block m = (addr − 0xC0000) >> 14, in the range 0..15. If bit m of high_map_i is 1, both outputs are 1, whatever shadow_cfg_i holds.
- R5: For an address in 0xC0000–0xFFFFF whose block bit in high_map_i is 0, take group g = m / 4 (g = 0 is 0xC0000–0xCFFFF). Then rd_ext_o equals bit (3 − g) of shadow_cfg_i.
- R6: Under the same condition as R5, wr_ext_o equals bit (7 − g) of shadow_cfg_i, independently of the read bit.
- R7: With shadow_cfg_i, low_map_i and high_map_i all zero, both outputs are 0 for every address.
- R8: ext_o equals wr_ext_o when is_write_i is 1, and equals rd_ext_o when is_write_i is 0.
- R9: The outputs follow a change of any configuration input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Memory address of the current access |
| is_write_i | input | 1 | 1 for a write access, 0 for a read access |
| shadow_cfg_i | input | 8 | Shadow control byte: bits [3:0] steer reads and bits [7:4] steer writes, per 64 KB group in reverse order |
| low_map_i | input | 32 | Channel-select bits for the 32 granules of 0x40000–0xBFFFF |
| high_map_i | input | 16 | Channel-select bits for the 16 granules of 0xC0000–0xFFFFF |
| rd_ext_o | output | 1 | Read target: 1 = I/O channel, 0 = board memory |
| wr_ext_o | output | 1 | Write target: 1 = I/O channel, 0 = board memory |
| ext_o | output | 1 | Target of the current access, chosen by is_write_i |

## Verification
Whenever the inputs change, the assertions check several rules: the fixed board routing below the decoded range, the paired read and write routing of the lower range, the forced channel routing of the upper range, the all-zero default, and the agreement between the qualified output and the two path outputs. They cannot check which bit of which byte controls a given granule, or which shadow bit belongs to which group. Those mappings are shown only by the bench sweep, which compares every granule, at both of its edges, against an independent model under random and directed configurations. Two bench scenarios cover the region boundaries and the immediate effect of a configuration change.

// File: rtl/memmap_pkg.sv
// Package: memmap_pkg
// Holds the address geometry of the decoder and the route type shared by its
// modules. Assumes a 20-bit address and 16 KB granules; the derived values
// follow from the base parameters.
package memmap_pkg;
    localparam int ADDR_W         = 20;
    localparam int GRAN_LOG2      = 14;
    localparam int BLK_W          = ADDR_W - GRAN_LOG2;
    localparam int LOW_FIRST_BLK  = 16;
    localparam int LOW_BLOCKS     = 32;
    localparam int HIGH_BLOCKS    = 16;
    localparam int HIGH_FIRST_BLK = LOW_FIRST_BLK + LOW_BLOCKS;
    localparam int LOW_IDX_W      = $clog2(LOW_BLOCKS);
    localparam int HIGH_IDX_W     = $clog2(HIGH_BLOCKS);
    localparam int GROUP_BLOCKS   = 4;
    localparam int GROUPS         = HIGH_BLOCKS / GROUP_BLOCKS;
    localparam int GROUP_W        = $clog2(GROUPS);
    localparam int GROUP_SHIFT    = $clog2(GROUP_BLOCKS);

    typedef enum logic [1:0] {
        REG_BASE = 2'd0,
        REG_LOW  = 2'd1,
        REG_HIGH = 2'd2
    } region_e;

    typedef struct packed {
        logic rd_ext;
        logic wr_ext;
    } route_t;
endpackage

// File: rtl/memmap_region_split.sv
// Module: memmap_region_split
// Classifies an address into the fixed base range, the lower mapped range or
// the upper shadow range. It also produces the granule index within the range
// and the 64 KB group index. Assumes the ranges are contiguous and aligned to
// a granule.
module memmap_region_split
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr_i,
    output region_e               region_o,
    output logic [LOW_IDX_W-1:0]  low_idx_o,
    output logic [HIGH_IDX_W-1:0] high_idx_o,
    output logic [GROUP_W-1:0]    group_o
);
    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] low_off;
    logic [BLK_W-1:0] high_off;

    // Purpose: take the granule number and the offsets from the range bases.
    always_comb begin
        blk      = addr_i[ADDR_W-1:GRAN_LOG2];
        low_off  = blk - BLK_W'(LOW_FIRST_BLK);
        high_off = blk - BLK_W'(HIGH_FIRST_BLK);
    end

    // Purpose: choose the range by comparing the granule against the bases.
    always_comb begin
        if (blk < BLK_W'(LOW_FIRST_BLK))
            region_o = REG_BASE;
        else if (blk < BLK_W'(HIGH_FIRST_BLK))
            region_o = REG_LOW;
        else
            region_o = REG_HIGH;
    end

    assign low_idx_o  = low_off[LOW_IDX_W-1:0];
    assign high_idx_o = high_off[HIGH_IDX_W-1:0];
    assign group_o    = high_idx_o[HIGH_IDX_W-1:GROUP_SHIFT];
endmodule

// File: rtl/memmap_bit_select.sv
// Module: memmap_bit_select
// Picks one select bit out of a granule map. The map is formed by joining
// configuration bytes with byte 0 lowest. Assumes NBITS is a power of two.
module memmap_bit_select #(
    parameter int NBITS = 32,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic [NBITS-1:0] map_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    // Purpose: index the map with the granule number.
    always_comb begin
        bit_o = map_i[idx_i];
    end
endmodule

// File: rtl/memmap_shadow_select.sv
// Module: memmap_shadow_select
// Turns the shadow control byte into a read route and a write route for one
// 64 KB group. Group g reads through bit (GROUPS-1-g) and writes through bit
// (2*GROUPS-1-g). Assumes the byte is exactly 2*GROUPS bits wide.
module memmap_shadow_select
    import memmap_pkg::*;
(
    input  logic [2*GROUPS-1:0]  shadow_cfg_i,
    input  logic [GROUP_W-1:0]   group_i,
    output route_t               route_o
);
    route_t per_group [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        assign per_group[g].rd_ext = shadow_cfg_i[GROUPS-1-g];
        assign per_group[g].wr_ext = shadow_cfg_i[2*GROUPS-1-g];
    end

    // Purpose: select the route of the addressed group.
    always_comb begin
        route_o = per_group[group_i];
    end
endmodule

// File: rtl/memmap_decoder.sv
// Module: memmap_decoder
// Top of the shadow and channel decoder. Combines the range classification,
// the two granule maps and the shadow control into separate read and write
// routes, plus the route of the current access. Purely combinational; has no
// clock or state. Assumes the configuration inputs are stable during an access.
module memmap_decoder
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   is_write_i,
    input  logic [2*GROUPS-1:0]    shadow_cfg_i,
    input  logic [LOW_BLOCKS-1:0]  low_map_i,
    input  logic [HIGH_BLOCKS-1:0] high_map_i,
    output logic                   rd_ext_o,
    output logic                   wr_ext_o,
    output logic                   ext_o
);
    region_e               region;
    logic [LOW_IDX_W-1:0]  low_idx;
    logic [HIGH_IDX_W-1:0] high_idx;
    logic [GROUP_W-1:0]    group;
    logic                  low_bit;
    logic                  high_bit;
    route_t                shadow_route;
    route_t                route;

    memmap_region_split i_split (
        .addr_i     (addr_i),
        .region_o   (region),
        .low_idx_o  (low_idx),
        .high_idx_o (high_idx),
        .group_o    (group)
    );

    memmap_bit_select #(.NBITS(LOW_BLOCKS)) i_low_sel (
        .map_i (low_map_i),
        .idx_i (low_idx),
        .bit_o (low_bit)
    );

    memmap_bit_select #(.NBITS(HIGH_BLOCKS)) i_high_sel (
        .map_i (high_map_i),
        .idx_i (high_idx),
        .bit_o (high_bit)
    );

    memmap_shadow_select i_shadow (
        .shadow_cfg_i (shadow_cfg_i),
        .group_i      (group),
        .route_o      (shadow_route)
    );

    // Purpose: merge the per-range decisions into one read/write route.
    always_comb begin
        unique case (region)
            REG_LOW:  route = '{rd_ext: low_bit, wr_ext: low_bit};
            REG_HIGH: route = high_bit ? '{rd_ext: 1'b1, wr_ext: 1'b1}
                                       : shadow_route;
            default:  route = '{rd_ext: 1'b0, wr_ext: 1'b0};
        endcase
    end

    assign rd_ext_o = route.rd_ext;
    assign wr_ext_o = route.wr_ext;
    assign ext_o    = is_write_i ? route.wr_ext : route.rd_ext;

    // Purpose: check the routing rules each time the inputs change.
    always_comb begin
        if (addr_i < ADDR_W'(LOW_FIRST_BLK << GRAN_LOG2))
            p_base_board_r1: assert (!rd_ext_o && !wr_ext_o)
                else $error("R1 base range not routed to board");
        if (region == REG_LOW)
            p_low_paired_r2: assert (rd_ext_o == wr_ext_o)
                else $error("R2 lower range read/write split");
        if (region == REG_HIGH && high_bit)
            p_high_override_r4: assert (rd_ext_o && wr_ext_o)
                else $error("R4 upper channel bit not honoured");
        if (shadow_cfg_i == '0 && low_map_i == '0 && high_map_i == '0)
            p_zero_cfg_r7: assert (!rd_ext_o && !wr_ext_o)
                else $error("R7 zero configuration not board");
        if (rd_ext_o == wr_ext_o)
            p_qualified_r8: assert (ext_o == rd_ext_o)
                else $error("R8 qualified route mismatch");
    end
endmodule

// File: tb/test_memmap_decoder.sv
// Bench for memmap_decoder: a seeded random sweep of every granule plus
// directed boundary and configuration-change cases, checked against a model.
module test_memmap_decoder;
    logic [19:0] addr;
    logic        is_wr;
    logic [7:0]  sh;
    logic [31:0] lo;
    logic [15:0] hi;
    logic        rd_ext, wr_ext, ext;
    logic        clk = 1'b0;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    memmap_decoder i_memmap_decoder (
        .addr_i       (addr),
        .is_write_i   (is_wr),
        .shadow_cfg_i (sh),
        .low_map_i    (lo),
        .high_map_i   (hi),
        .rd_ext_o     (rd_ext),
        .wr_ext_o     (wr_ext),
        .ext_o        (ext)
    );

    // Model: returns {read_to_channel, write_to_channel}.
    function automatic logic [1:0] model(logic [19:0] a, logic [7:0] s,
                                         logic [31:0] l, logic [15:0] h);
        int b = int'(a >> 14);
        int m;
        int g;
        if (b < 16) return 2'b00;
        if (b < 48) return {l[b-16], l[b-16]};
        m = b - 48;
        if (h[m]) return 2'b11;
        g = m / 4;
        return {s[3-g], s[7-g]};
    endfunction

    function automatic string req_of(logic [19:0] a, logic [31:0] l,
                                     logic [15:0] h);
        int b = int'(a >> 14);
        if (b < 16) return "R1";
        if (b < 48) return l[b-16] ? "R2" : "R3";
        if (h[b-48]) return "R4";
        return "R5/R6";
    endfunction

    task automatic check_now(string req);
        logic [1:0] exp = model(addr, sh, lo, hi);
        logic       exp_q = is_wr ? exp[0] : exp[1];
        checks++;
        if (rd_ext !== exp[1] || wr_ext !== exp[0] || ext !== exp_q) begin
            failures++;
            $display("FAIL %s addr=%05h wr=%0b actual rd/wr/q=%0b%0b%0b expected=%0b%0b%0b",
                     req, addr, is_wr, rd_ext, wr_ext, ext, exp[1], exp[0], exp_q);
        end
    endtask

    task automatic access(logic [19:0] a, logic w, string req);
        @(negedge clk);
        addr  = a;
        is_wr = w;
        #1;
        check_now(req);
    endtask

    initial begin
        addr = '0; is_wr = 1'b0; sh = '0; lo = '0; hi = '0;
        void'($urandom(32'd20240917));

        // R7: all-zero configuration, one access per granule
        for (int b = 0; b < 64; b++)
            access(20'(b << 14) | 20'h01230, b[0], "R7");

        // R1: base range ignores a fully set configuration
        sh = 8'hFF; lo = '1; hi = '1;
        access(20'h00000, 1'b0, "R1");
        access(20'h3FFFF, 1'b1, "R1");
        access(20'h40000, 1'b0, "R2");
        access(20'hBFFFF, 1'b1, "R2");
        access(20'hC0000, 1'b0, "R4");
        access(20'hFFFFF, 1'b1, "R4");

        // R5 and R6: each shadow bit alone, with the upper channel bits cleared
        lo = '0; hi = '0;
        for (int k = 0; k < 8; k++) begin
            sh = 8'(1 << k);
            for (int g = 0; g < 4; g++) begin
                access(20'hC0000 + 20'(g << 16), 1'b0, "R5");
                access(20'hC0000 + 20'(g << 16) + 20'hFFFF, 1'b1, "R6");
            end
        end

        // R2 and R3: a single lower-range bit at each position
        sh = '0;
        for (int n = 0; n < 32; n++) begin
            lo = 32'(1) << n;
            access(20'h40000 + 20'(n << 14), 1'b1, "R2");
            if (n > 0) access(20'h40000 + 20'((n - 1) << 14) + 20'h3FFF, 1'b0, "R3");
        end

        // R4: a single upper bit overrides a shadow byte that points at the board
        lo = '0; sh = 8'h00;
        for (int m = 0; m < 16; m++) begin
            hi = 16'(1) << m;
            access(20'hC0000 + 20'(m << 14), 1'b0, "R4");
        end

        // R9: a configuration change with no clock edge is seen at once
        hi = '0; sh = '0; lo = '0;
        @(negedge clk);
        addr = 20'h5C000; is_wr = 1'b0;
        #0.5 lo[7] = 1'b1;
        #0.5 check_now("R9");
        sh = 8'h08; addr = 20'hC4000;
        #0.5 check_now("R9");
        sh = 8'h80; is_wr = 1'b1;
        #0.5 check_now("R8");

        // Random sweep of every granule, both edges and both directions
        for (int r = 0; r < 12; r++) begin
            sh = 8'($urandom);
            lo = $urandom;
            hi = 16'($urandom);
            for (int b = 0; b < 64; b++) begin
                logic [19:0] a0 = 20'(b << 14);
                access(a0, 1'($urandom), req_of(a0, lo, hi));
                access(a0 + 20'h3FFF, 1'($urandom), req_of(a0, lo, hi));
                access(a0 + 20'($urandom % 16384), 1'b1, "R8");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule